// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a small processor core that runs a 16-bit load/store instruction set one instruction at a time. Each instruction moves through a fixed order of phases: instruction fetch, decode, address evaluation, operand fetch, execute and result store. An instruction enters only the phases it needs. The core holds eight 16-bit general registers, a program counter, an instruction register and a three-flag condition code (negative, zero, positive). The supported operations are register or immediate add and bitwise and, bitwise not, base-plus-offset load and store, jump through a register, and conditional branch relative to the program counter.

The core reaches memory only through an address register and a data register. The memory is synchronous and word-addressed. A read strobe makes the memory register the addressed word on that clock edge, and the core latches that word into its data register on the following cycle. A write strobe stores the data register at the address register on that edge. A store always fills the data register first, then the address register, and only then asserts the write strobe.

Controller states and transitions (4-space-indented FSM, one state per cycle):
`FADDR` (address register takes the PC) → `FREAD` (read strobe) → `FLATCH` (data register takes the memory word) → `FLOAD` (instruction register takes the data register, PC advances by one) → `DECODE`. From `DECODE`: a load or store goes to `EVAL`; add, and, not, jump and branch go to `EXEC`; any other opcode returns to `FADDR`. `EVAL` (effective address = base + offset) goes to `STDATA` for a store or to `MADDR` for a load. `STDATA` (data register takes the source register) → `MADDR`. `MADDR` (address register takes the effective address) goes to `MWRITE` for a store or to `MREAD` for a load. `MREAD` → `MLATCH` → `STORE`. `MWRITE` → `FADDR`. `EXEC` goes to `FADDR` for a jump or branch and to `STORE` for an ALU operation. `STORE` (register write and condition update) → `FADDR`.

Top module: `mc16_core`

## Requirements
- R1: While reset is held and afterwards, the PC is 0 and the condition code is Z. Both strobes are low and the address output is 0. The first read after reset is at address 0, one cycle after reset is released.
- R2: Each fetch loads the address register with the PC. It asserts the read strobe for exactly one cycle, captures the returned word through the data register into the instruction register, and then increments the PC by 1.
- R3: Opcode 0001 is add and 0101 is and. The destination is bits [11:9] and the first source is bits [8:6]. When bit 5 is 0, the second source is the register in bits [2:0]. When bit 5 is 1, the second source is bits [4:0] sign-extended.
- R4: Opcode 1001 writes the bitwise inverse of the register in bits [8:6] to the register in bits [11:9].
- R5: Opcode 0110 reads memory at (register in bits [8:6]) + sign-extended bits [5:0] and writes the word to the register in bits [11:9].
- R6: Opcode 0111 writes the register in bits [11:9] to address (register in bits [8:6]) + sign-extended bits [5:0]. The data register is loaded before the address register, and the write strobe is high for one cycle with its data held from the previous cycle.
- R7: After add, and, not and load, exactly one of N (bit 2), Z (bit 1) and P (bit 0) is set, from the sign and zero-ness of the written value. Store, jump and branch leave the flags unchanged.
- R8: Opcode 0000 tests flags with bit 11 = n, bit 10 = z and bit 9 = p. If any selected flag is set, the PC becomes the incremented PC plus sign-extended bits [8:0]. Otherwise execution falls through.
- R9: Opcode 1100 loads the PC with the register in bits [8:6].
- R10: Every other opcode only fetches. It changes no register, no flag and no memory word.
- R11: Measured from the first cycle of one fetch to the next, instructions take these cycles: add/and/not 7, load 10, store 9, jump and branch 6, unsupported 5. The fetch read falls in the 2nd cycle, a load's data read in the 8th, and a store's write in the 9th.
- R12: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Memory address register contents |
| mem_rd | output | 1 | Read strobe; memory registers the word on this edge |
| mem_wr | output | 1 | Write strobe; memory stores mem_wdata at mem_addr |
| mem_wdata | output | 16 | Memory data register contents |
| mem_rdata | input | 16 | Word returned by memory the cycle after mem_rd |

## Verification
The bench targets three kinds of faults.

First, cycle-exact phase skipping. Every read and write is compared against a reference that knows each instruction's length. A controller that visits an unneeded phase, or drops one, therefore shifts every later event.

Second, negative immediates and offsets, and aliasing of memory addresses. Here a missing sign extension would load from or store to the wrong word.

Third, flag behaviour: the Z flag forced at reset, branches whose selected flags are all clear, and stores, jumps and branches that must leave the flags alone. A core that got these wrong would take or skip a branch wrongly, and every fetch address after it would differ. Self-modifying stores and jumps to arbitrary addresses in random programs also check that fetch always reads memory as it stands.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned NREGS   = 8;
    localparam int unsigned RADDR_W = $clog2(NREGS);
    localparam int unsigned OPC_W   = 4;
    localparam int unsigned NOPC    = 1 << OPC_W;

    localparam logic [OPC_W-1:0] OPC_BR  = 4'h0;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'h1;
    localparam logic [OPC_W-1:0] OPC_AND = 4'h5;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'h6;
    localparam logic [OPC_W-1:0] OPC_STR = 4'h7;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'h9;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'hC;

    localparam logic [NOPC-1:0] SUP_MASK = NOPC'((1 << OPC_BR) | (1 << OPC_ADD) |
        (1 << OPC_AND) | (1 << OPC_LDR) | (1 << OPC_STR) | (1 << OPC_NOT) | (1 << OPC_JMP));

    typedef enum logic [3:0] {
        S_FADDR, S_FREAD, S_FLATCH, S_FLOAD, S_DECODE, S_EVAL, S_STDATA,
        S_MADDR, S_MREAD, S_MLATCH, S_MWRITE, S_EXEC, S_STORE
    } phase_t;

    typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT, ALU_PASS} alu_op_t;
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
    parameter int unsigned DW = 16,
    parameter int unsigned N  = 8,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_c,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_c
);
    logic [DW-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (waddr == AW'(g)))
                regs[g] <= wdata;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
    import mc16_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  alu_op_t       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_AND:  y = a & b;
            ALU_NOT:  y = ~a;
            ALU_PASS: y = a;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
    import mc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    phase_t state, state_nx;
    logic [DATA_W-1:0] pc, ir, mar, mdr, ea, alu_q;
    logic [2:0] cc, wb_cc;
    logic [NOPC-1:0] dec_oh;
    logic is_add, is_and, is_not, is_ldr, is_str, is_jmp, is_br, unsup;
    logic [RADDR_W-1:0] f_dr, f_sr1, f_sr2;
    logic [DATA_W-1:0] imm5_x, off6_x, off9_x;
    logic [DATA_W-1:0] r_a, r_b, r_c, alu_b, alu_y, wb_val;
    alu_op_t alu_op;
    logic rf_we, br_take;

    // Opcode decode: one control line per opcode value
    always_comb begin
        dec_oh = '0;
        dec_oh[ir[15:12]] = 1'b1;
    end
    assign is_add = dec_oh[OPC_ADD];
    assign is_and = dec_oh[OPC_AND];
    assign is_not = dec_oh[OPC_NOT];
    assign is_ldr = dec_oh[OPC_LDR];
    assign is_str = dec_oh[OPC_STR];
    assign is_jmp = dec_oh[OPC_JMP];
    assign is_br  = dec_oh[OPC_BR];
    assign unsup  = |(dec_oh & ~SUP_MASK);

    assign f_dr   = ir[11:9];
    assign f_sr1  = ir[8:6];
    assign f_sr2  = ir[2:0];
    assign imm5_x = {{(DATA_W-5){ir[4]}}, ir[4:0]};
    assign off6_x = {{(DATA_W-6){ir[5]}}, ir[5:0]};
    assign off9_x = {{(DATA_W-9){ir[8]}}, ir[8:0]};

    mc16_regfile #(.DW(DATA_W), .N(NREGS)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(f_dr), .wdata(wb_val),
        .ra_a(f_sr1), .ra_b(f_sr2), .ra_c(f_dr),
        .rd_a(r_a), .rd_b(r_b), .rd_c(r_c)
    );

    always_comb begin
        if (is_and)      alu_op = ALU_AND;
        else if (is_not) alu_op = ALU_NOT;
        else             alu_op = ALU_ADD;
    end
    assign alu_b = ir[5] ? imm5_x : r_b;

    mc16_alu #(.DW(DATA_W)) u_alu (.op(alu_op), .a(r_a), .b(alu_b), .y(alu_y));

    assign br_take = (ir[11] & cc[2]) | (ir[10] & cc[1]) | (ir[9] & cc[0]);
    assign wb_val  = is_ldr ? mdr : alu_q;
    assign wb_cc   = wb_val[DATA_W-1] ? 3'b100 : ((wb_val == '0) ? 3'b010 : 3'b001);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FADDR;
        else        state <= state_nx;
    end

    // Phase sequencing
    always_comb begin
        unique case (state)
            S_FADDR:  state_nx = S_FREAD;
            S_FREAD:  state_nx = S_FLATCH;
            S_FLATCH: state_nx = S_FLOAD;
            S_FLOAD:  state_nx = S_DECODE;
            S_DECODE: begin
                if (is_ldr || is_str) state_nx = S_EVAL;
                else if (unsup)       state_nx = S_FADDR;
                else                  state_nx = S_EXEC;
            end
            S_EVAL:   state_nx = is_str ? S_STDATA : S_MADDR;
            S_STDATA: state_nx = S_MADDR;
            S_MADDR:  state_nx = is_str ? S_MWRITE : S_MREAD;
            S_MREAD:  state_nx = S_MLATCH;
            S_MLATCH: state_nx = S_STORE;
            S_MWRITE: state_nx = S_FADDR;
            S_EXEC:   state_nx = (is_jmp || is_br) ? S_FADDR : S_STORE;
            S_STORE:  state_nx = S_FADDR;
            default:  state_nx = S_FADDR;
        endcase
    end

    // Strobes and write enable
    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        rf_we  = 1'b0;
        unique case (state)
            S_FREAD, S_MREAD: mem_rd = 1'b1;
            S_MWRITE:         mem_wr = 1'b1;
            S_STORE:          rf_we  = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            ir    <= '0;
            mar   <= '0;
            mdr   <= '0;
            ea    <= '0;
            alu_q <= '0;
            cc    <= 3'b010;
        end else begin
            unique case (state)
                S_FADDR:  mar <= pc;
                S_FLATCH: mdr <= mem_rdata;
                S_FLOAD: begin
                    ir <= mdr;
                    pc <= pc + 1'b1;
                end
                S_EVAL:   ea  <= r_a + off6_x;
                S_STDATA: mdr <= r_c;
                S_MADDR:  mar <= ea;
                S_MLATCH: mdr <= mem_rdata;
                S_EXEC: begin
                    alu_q <= alu_y;
                    if (is_jmp)               pc <= r_a;
                    else if (is_br && br_take) pc <= pc + off9_x;
                end
                S_STORE:  cc <= wb_cc;
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;

    // R7
    cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1);
    // R7
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && (is_jmp || is_br)) |=> $stable(cc));
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FLOAD) |=> (pc == $past(pc) + 1'b1));
    // R2
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // R6
    wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $stable(mem_wdata));
    // R10
    unsup_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && unsup) |=> (state == S_FADDR && $stable(pc) && $stable(cc)));
endmodule

// File: tb/mc16_core_tb.sv
module mc16_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;
    localparam int MEM_N      = 256;
    localparam int EV_N       = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic mem_rd, mem_wr;

    logic [15:0] mem [MEM_N];
    logic [15:0] ref_mem [MEM_N];
    logic [15:0] img [MEM_N];
    logic [15:0] ref_r [8];
    logic [15:0] ref_pc;
    logic [2:0]  ref_cc;
    int iss_cyc;

    int exp_rd_c [EV_N]; logic [15:0] exp_rd_a [EV_N]; int n_exp_rd;
    int exp_wr_c [EV_N]; logic [15:0] exp_wr_a [EV_N]; logic [15:0] exp_wr_d [EV_N]; int n_exp_wr;
    int act_rd_c [EV_N]; logic [15:0] act_rd_a [EV_N]; int n_act_rd;
    int act_wr_c [EV_N]; logic [15:0] act_wr_a [EV_N]; logic [15:0] act_wr_d [EV_N]; int n_act_wr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc16_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Synchronous word memory, address aliased to its depth
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] = mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Instruction encoders
    function automatic logic [15:0] e_rr(logic [3:0] op, int d, int s1, int s2);
        return {op, 3'(d), 3'(s1), 3'b000, 3'(s2)};
    endfunction
    function automatic logic [15:0] e_ri(logic [3:0] op, int d, int s1, int imm);
        return {op, 3'(d), 3'(s1), 1'b1, 5'(imm)};
    endfunction
    function automatic logic [15:0] e_not(int d, int s1);
        return {4'h9, 3'(d), 3'(s1), 6'h3F};
    endfunction
    function automatic logic [15:0] e_mem(logic [3:0] op, int r, int base, int off);
        return {op, 3'(r), 3'(base), 6'(off)};
    endfunction
    function automatic logic [15:0] e_jmp(int base);
        return {4'hC, 3'b000, 3'(base), 6'h00};
    endfunction
    function automatic logic [15:0] e_br(bit n, bit z, bit p, int off);
        return {4'h0, n, z, p, 9'(off)};
    endfunction

    function automatic logic [15:0] rand_ins();
        logic [11:0] f;
        logic [3:0] op;
        f = 12'($urandom);
        case ($urandom % 10)
            0, 9:    op = 4'h1;
            1:       op = 4'h5;
            2:       op = 4'h9;
            3:       op = 4'h6;
            4, 5:    op = 4'h7;
            6:       op = 4'h0;
            7:       op = 4'hC;
            default: begin
                case ($urandom % 9)
                    0: op = 4'h2; 1: op = 4'h3; 2: op = 4'h4;
                    3: op = 4'h8; 4: op = 4'hA; 5: op = 4'hB;
                    6: op = 4'hD; 7: op = 4'hE; default: op = 4'hF;
                endcase
            end
        endcase
        return {op, f};
    endfunction

    // Reference: one instruction, with the cycle of each memory event
    task automatic iss_step();
        logic [15:0] ins, b, v, ea;
        logic [2:0] d, s1, s2;
        int cy;
        bit wb;
        ins = ref_mem[ref_pc[7:0]];
        exp_rd_c[n_exp_rd] = iss_cyc + 1; exp_rd_a[n_exp_rd] = ref_pc; n_exp_rd++;
        ref_pc = ref_pc + 16'd1;
        d = ins[11:9]; s1 = ins[8:6]; s2 = ins[2:0];
        wb = 1'b0; v = '0; cy = 5;
        case (ins[15:12])
            4'h1, 4'h5: begin
                b = ins[5] ? {{11{ins[4]}}, ins[4:0]} : ref_r[s2];
                v = (ins[15:12] == 4'h1) ? ref_r[s1] + b : ref_r[s1] & b;
                wb = 1'b1; cy = 7;
            end
            4'h9: begin v = ~ref_r[s1]; wb = 1'b1; cy = 7; end
            4'h6: begin
                ea = ref_r[s1] + {{10{ins[5]}}, ins[5:0]};
                exp_rd_c[n_exp_rd] = iss_cyc + 7; exp_rd_a[n_exp_rd] = ea; n_exp_rd++;
                v = ref_mem[ea[7:0]]; wb = 1'b1; cy = 10;
            end
            4'h7: begin
                ea = ref_r[s1] + {{10{ins[5]}}, ins[5:0]};
                exp_wr_c[n_exp_wr] = iss_cyc + 8; exp_wr_a[n_exp_wr] = ea;
                exp_wr_d[n_exp_wr] = ref_r[d]; n_exp_wr++;
                ref_mem[ea[7:0]] = ref_r[d]; cy = 9;
            end
            4'hC: begin ref_pc = ref_r[s1]; cy = 6; end
            4'h0: begin
                if ((ins[11] && ref_cc[2]) || (ins[10] && ref_cc[1]) || (ins[9] && ref_cc[0]))
                    ref_pc = ref_pc + {{7{ins[8]}}, ins[8:0]};
                cy = 6;
            end
            default: cy = 5;
        endcase
        if (wb) begin
            ref_r[d] = v;
            ref_cc = v[15] ? 3'b100 : ((v == 16'd0) ? 3'b010 : 3'b001);
        end
        iss_cyc += cy;
    endtask

    task automatic run_prog(input string tag, input int k);
        bit both;
        rst_n = 1'b0;
        for (int i = 0; i < MEM_N; i++) begin mem[i] = img[i]; ref_mem[i] = img[i]; end
        for (int i = 0; i < 8; i++) ref_r[i] = '0;
        ref_pc = '0; ref_cc = 3'b010; iss_cyc = 0; n_exp_rd = 0; n_exp_wr = 0;
        for (int i = 0; i < k; i++) iss_step();
        repeat (3) @(negedge clk);
        chk(mem_addr == 16'd0, "R1 reset address", mem_addr, 16'd0);
        chk({mem_rd, mem_wr} == 2'b00, "R1 reset strobes", 16'({mem_rd, mem_wr}), 16'd0);
        n_act_rd = 0; n_act_wr = 0; both = 1'b0;
        rst_n = 1'b1;
        for (int c = 0; c < iss_cyc; c++) begin
            #1;
            if (mem_rd && mem_wr) both = 1'b1;
            if (mem_rd && n_act_rd < EV_N) begin
                act_rd_c[n_act_rd] = c; act_rd_a[n_act_rd] = mem_addr; n_act_rd++;
            end
            if (mem_wr && n_act_wr < EV_N) begin
                act_wr_c[n_act_wr] = c; act_wr_a[n_act_wr] = mem_addr;
                act_wr_d[n_act_wr] = mem_wdata; n_act_wr++;
            end
            @(negedge clk);
        end
        chk(!both, {tag, " R12 strobes together"}, 16'(both), 16'd0);
        chk(n_act_rd == n_exp_rd, {tag, " R2 R11 read count"}, 16'(n_act_rd), 16'(n_exp_rd));
        chk(n_act_wr == n_exp_wr, {tag, " R6 R11 write count"}, 16'(n_act_wr), 16'(n_exp_wr));
        for (int i = 0; i < n_exp_rd && i < n_act_rd; i++) begin
            chk(act_rd_c[i] == exp_rd_c[i], {tag, " R2 R5 R11 read cycle"}, 16'(act_rd_c[i]), 16'(exp_rd_c[i]));
            chk(act_rd_a[i] == exp_rd_a[i], {tag, " R2 R5 read address"}, act_rd_a[i], exp_rd_a[i]);
        end
        for (int i = 0; i < n_exp_wr && i < n_act_wr; i++) begin
            chk(act_wr_c[i] == exp_wr_c[i], {tag, " R6 R11 write cycle"}, 16'(act_wr_c[i]), 16'(exp_wr_c[i]));
            chk(act_wr_a[i] == exp_wr_a[i], {tag, " R6 write address"}, act_wr_a[i], exp_wr_a[i]);
            chk(act_wr_d[i] == exp_wr_d[i], {tag, " R6 write data"}, act_wr_d[i], exp_wr_d[i]);
        end
        for (int i = 0; i < MEM_N; i++)
            chk(mem[i] == ref_mem[i], {tag, " final memory"}, mem[i], ref_mem[i]);
    endtask

    initial begin : watchdog
        repeat (WDOG_CYC) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual cycles %0d expected below %0d", WDOG_CYC, WDOG_CYC);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = $urandom(32'h5EED);

        // R1 R8: reset Z flag, taken and not-taken branches
        for (int i = 0; i < MEM_N; i++) img[i] = '0;
        img[0]  = e_br(0, 1, 0, 2);
        img[1]  = e_ri(4'h1, 1, 1, 1);
        img[2]  = e_ri(4'h1, 1, 1, 1);
        img[3]  = e_ri(4'h1, 1, 0, -1);
        img[4]  = e_br(0, 0, 1, 5);
        img[5]  = e_br(1, 0, 0, 1);
        img[6]  = e_ri(4'h1, 2, 2, 1);
        img[7]  = e_ri(4'h1, 2, 0, 0);
        img[8]  = e_mem(4'h7, 1, 0, 20);
        img[9]  = e_br(1, 0, 0, 1);
        img[10] = e_br(1, 1, 1, -1);
        run_prog("R1 R8", 9);

        // R3 R4 R5 R6 R7: ALU register/immediate, not, loads with negative offset, stores
        for (int i = 0; i < MEM_N; i++) img[i] = '0;
        img[16] = 16'h8001; img[17] = 16'h1234;
        img[0]  = e_mem(4'h6, 2, 0, 16);
        img[1]  = e_mem(4'h6, 3, 0, 17);
        img[2]  = e_rr(4'h1, 4, 2, 3);
        img[3]  = e_ri(4'h5, 5, 3, -16);
        img[4]  = e_not(6, 3);
        img[5]  = e_rr(4'h5, 7, 2, 3);
        img[6]  = e_ri(4'h1, 1, 0, 15);
        img[7]  = e_ri(4'h1, 1, 1, 5);
        img[8]  = e_mem(4'h6, 0, 1, -3);
        img[9]  = e_mem(4'h7, 4, 1, 10);
        img[10] = e_mem(4'h7, 5, 1, 11);
        img[11] = e_mem(4'h7, 6, 1, 12);
        img[12] = e_mem(4'h7, 7, 1, 13);
        img[13] = e_mem(4'h7, 0, 1, -1);
        img[14] = e_mem(4'h7, 2, 1, 14);
        img[15] = e_br(1, 1, 1, -1);
        run_prog("R3 R4 R5 R6 R7", 17);

        // R9 R10: register jump, unsupported opcodes leave state alone
        for (int i = 0; i < MEM_N; i++) img[i] = '0;
        img[0] = e_ri(4'h1, 1, 0, 9);
        img[1] = e_jmp(1);
        for (int i = 2; i < 9; i++) img[i] = e_mem(4'h7, 1, 0, 30);
        img[9]  = 16'hD123;
        img[10] = 16'hF0FF;
        img[11] = 16'h8000;
        img[12] = e_br(0, 0, 1, 1);
        img[13] = e_mem(4'h7, 1, 0, 29);
        img[14] = e_mem(4'h7, 1, 0, 31);
        img[15] = e_br(1, 1, 1, -1);
        run_prog("R9 R10", 8);

        // Random programs: every opcode, self-modifying stores, arbitrary jumps
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < MEM_N; i++) img[i] = rand_ins();
            run_prog("R3 R4 R5 R6 R7 R8 R9 R10 R11 random", 40);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule